// File: doc/BRIEF.md
# Three-Phase Complementary PWM Controller

The block drives three half-bridges from one shared time base. Each phase owns one compare value. The counter runs either as a sawtooth or as an up/down triangle. The high-side output of a phase is active while the counter is below that phase's compare value, and the low-side output takes the rest of the period. A programmable dead time holds both outputs off around every handover, so the two switches of a bridge never conduct together.

Configuration inputs act as a front buffer. Period, compare values, dead time, mode and trigger point are copied into working registers only when the counter is about to return to zero. A compare value that would leave either side on for less than twice the dead time is replaced, for the whole period, by full-off or full-on, so no runt pulses appear. Three fault inputs override all six gates at once through a combinational path. A static bit chooses between releasing the gates (enable low) and driving them to their inactive level. The fault is remembered until it is cleared, and the clear only works once every fault input is quiet. An ADC trigger pulse marks one chosen counter value in every period.

Top module: `pwm3_ctrl`

## Requirements
- R1: `gate_o[2k]` is the high-side output and `gate_o[2k+1]` the low-side output of phase k. Compare value k is `duty_i[12k +: 12]`. The high side is active while the counter is below that value.
- R2: In edge mode (`center_i`=0) the counter runs 0..P and the period is P+1 cycles. With compare d and dead time D, the high side is active for d-D cycles per period and the low side for P+1-d-D cycles.
- R3: The two outputs of one phase are never active in the same cycle, and all six gates are inactive while reset is held.
- R4: After one side of a phase turns off, the other side turns on exactly D cycles later.
- R5: In center mode (`center_i`=1) the counter runs 0..P and then P-1..1, giving a period of 2P cycles. The high side is active for 2d-1-D cycles and the low side for 2P-2d+1-D cycles.
- R6: New period, compare, dead-time, mode and trigger values take effect only when the counter returns to zero. A pulse already in progress keeps its old width.
- R7: If one side's undelayed on-time in a period would be nonzero but shorter than 2D, that side stays off for the whole period and the other side stays on.
- R8: While any `fault_i` bit is high, the outputs are overridden in the same cycle. With `fault_hiz_i`=1 every `gate_oe_o` bit is 0. With `fault_hiz_i`=0 every `gate_oe_o` bit is 1 and every gate is at its inactive level.
- R9: The fault override persists after the fault inputs return low. It ends only when `fault_clr_i` is pulsed while all fault inputs are low.
- R10: With `pol_low_i`=1 an active output drives 0 and an inactive output drives 1. With `pol_low_i`=0 the levels are the other way round.
- R11: `adc_trig_o` is a one-cycle pulse, issued once per period on the cycle after the counter equals the trigger point while counting up. Its lag after the high-side rising edge is the trigger point minus D cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| center_i | input | 1 | 1 selects up/down counting, 0 selects sawtooth |
| period_i | input | 12 | Counter top value P |
| duty_i | input | 36 | Three compare values, phase k at bits 12k+11..12k |
| dead_i | input | 8 | Dead time D in clock cycles |
| trig_pt_i | input | 12 | Counter value that fires the ADC trigger |
| pol_low_i | input | 1 | 1 makes the gates active-low |
| fault_i | input | 3 | Emergency stop inputs, active high |
| fault_hiz_i | input | 1 | Fault action: 1 releases the gates, 0 drives them inactive |
| fault_clr_i | input | 1 | Clears the remembered fault once the inputs are low |
| gate_o | output | 6 | Gate levels, high side at even index |
| gate_oe_o | output | 6 | Per-gate output enable, 0 means high impedance |
| adc_trig_o | output | 1 | One-cycle ADC trigger pulse |

## Verification
The hardest case to reach from the ports is a compare value that changes while a pulse is in flight. The stimulus waits for the high-side rising edge of phase 0 and only then writes a much smaller compare value. The pulse measured from that edge must keep the old width, and the next pulse must take the new one. The runt rule is reached the same way. The bench picks compare values just inside the 2D limit on the low side of one phase and on the high side of another, waits out the load point, and then samples a whole window in which one gate must never move.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;

  // Undelayed high-side on-time, in cycles, for compare value d.
  function automatic int unsigned hi_cycles(int unsigned d, int unsigned per, logic center);
    if (d > per) return center ? 2 * per : per + 1;
    if (center) return (d == 0) ? 0 : 2 * d - 1;
    return d;
  endfunction

  // Compare value actually used for a period, after the runt rule.
  function automatic int unsigned shape_duty(int unsigned d, int unsigned dead,
                                             int unsigned per, logic center);
    int unsigned full, hi, lo, dc;
    full = center ? 2 * per : per + 1;
    dc   = (d > per) ? per + 1 : d;
    hi   = hi_cycles(dc, per, center);
    lo   = full - hi;
    if (hi != 0 && hi < 2 * dead) return 0;
    if (lo != 0 && lo < 2 * dead) return per + 1;
    return dc;
  endfunction

endpackage

// File: rtl/pwm3_timebase.sv
module pwm3_timebase #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          center_i,
  input  logic [CW-1:0] period_i,
  output logic [CW-1:0] cnt_o,
  output logic          up_o,
  output logic          wrap_o
);
  logic [CW-1:0] cnt, nxt;
  logic          up, nxt_up;

  always_comb begin
    nxt    = cnt;
    nxt_up = up;
    if (!center_i) begin
      nxt_up = 1'b1;
      nxt    = (cnt >= period_i) ? '0 : cnt + 1'b1;
    end else if (up) begin
      if (cnt >= period_i) begin
        nxt    = (period_i == '0) ? '0 : period_i - 1'b1;
        nxt_up = (period_i <= CW'(1));
      end else begin
        nxt = cnt + 1'b1;
      end
    end else begin
      nxt = (cnt == '0) ? '0 : cnt - 1'b1;
      if (cnt <= CW'(1)) nxt_up = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      up  <= 1'b1;
    end else begin
      cnt <= nxt;
      up  <= nxt_up;
    end
  end

  assign cnt_o  = cnt;
  assign up_o   = up;
  assign wrap_o = (nxt == '0);
endmodule

// File: rtl/pwm3_deadband.sv
module pwm3_deadband #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          raw_i,
  input  logic [DW-1:0] dead_i,
  output logic          hi_o,
  output logic          lo_o
);
  logic          side;
  logic [DW-1:0] wait_cnt;
  logic          settled;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      side     <= 1'b0;
      wait_cnt <= '1;
    end else if (raw_i != side) begin
      side     <= raw_i;
      wait_cnt <= dead_i;
    end else if (wait_cnt != '0) begin
      wait_cnt <= wait_cnt - 1'b1;
    end
  end

  assign settled = (wait_cnt == '0);
  assign hi_o    = side & settled;
  assign lo_o    = ~side & settled;
endmodule

// File: rtl/pwm3_fault_guard.sv
module pwm3_fault_guard #(
  parameter int NF = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] fault_i,
  input  logic          clr_i,
  output logic          force_o,
  output logic          latched_o
);
  logic any_fault, s1, s2, latched;

  assign any_fault = |fault_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1      <= 1'b0;
      s2      <= 1'b0;
      latched <= 1'b0;
    end else begin
      s1 <= any_fault;
      s2 <= s1;
      if (s2) latched <= 1'b1;
      else if (clr_i && !s1 && !any_fault) latched <= 1'b0;
    end
  end

  assign latched_o = latched;
  assign force_o   = any_fault | latched;
endmodule

// File: rtl/pwm3_ctrl.sv
module pwm3_ctrl #(
  parameter int NPH = 3,
  parameter int CW  = 12,
  parameter int DW  = 8,
  parameter int NF  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              center_i,
  input  logic [CW-1:0]     period_i,
  input  logic [NPH*CW-1:0] duty_i,
  input  logic [DW-1:0]     dead_i,
  input  logic [CW-1:0]     trig_pt_i,
  input  logic              pol_low_i,
  input  logic [NF-1:0]     fault_i,
  input  logic              fault_hiz_i,
  input  logic              fault_clr_i,
  output logic [2*NPH-1:0]  gate_o,
  output logic [2*NPH-1:0]  gate_oe_o,
  output logic              adc_trig_o
);
  localparam int NG  = 2 * NPH;
  localparam int DUW = CW + 1;

  logic [CW-1:0]      period_act, trig_act;
  logic [DW-1:0]      dead_act;
  logic               center_act;
  logic [NPH*DUW-1:0] duty_act_flat;
  logic               primed, load_evt;
  logic [CW-1:0]      cnt_w;
  logic               up_w, wrap_w;
  logic [NPH-1:0]     raw_w;
  logic [NG-1:0]      act_w;
  logic               force_w, fault_latched;
  logic               adc_q;

  assign load_evt = wrap_w | ~primed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      primed        <= 1'b0;
      period_act    <= '0;
      trig_act      <= '0;
      dead_act      <= '0;
      center_act    <= 1'b0;
      duty_act_flat <= '0;
    end else if (load_evt) begin
      primed     <= 1'b1;
      period_act <= period_i;
      trig_act   <= trig_pt_i;
      dead_act   <= dead_i;
      center_act <= center_i;
      for (int k = 0; k < NPH; k++) begin
        duty_act_flat[k*DUW +: DUW] <= DUW'(pwm3_pkg::shape_duty(
          int'(duty_i[k*CW +: CW]), int'(dead_i), int'(period_i), center_i));
      end
    end
  end

  pwm3_timebase #(.CW(CW)) u_tb (
    .clk(clk), .rst_n(rst_n), .center_i(center_act), .period_i(period_act),
    .cnt_o(cnt_w), .up_o(up_w), .wrap_o(wrap_w)
  );

  generate
    for (genvar k = 0; k < NPH; k++) begin : g_phase
      assign raw_w[k] = ({1'b0, cnt_w} < duty_act_flat[k*DUW +: DUW]);
      pwm3_deadband #(.DW(DW)) u_db (
        .clk(clk), .rst_n(rst_n), .raw_i(raw_w[k]), .dead_i(dead_act),
        .hi_o(act_w[2*k]), .lo_o(act_w[2*k+1])
      );
    end
  endgenerate

  pwm3_fault_guard #(.NF(NF)) u_fg (
    .clk(clk), .rst_n(rst_n), .fault_i(fault_i), .clr_i(fault_clr_i),
    .force_o(force_w), .latched_o(fault_latched)
  );

  always_comb begin
    for (int i = 0; i < NG; i++) begin
      gate_o[i]    = force_w ? pol_low_i : (act_w[i] ^ pol_low_i);
      gate_oe_o[i] = ~(force_w & fault_hiz_i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) adc_q <= 1'b0;
    else        adc_q <= (cnt_w == trig_act) && up_w;
  end

  assign adc_trig_o = adc_q;
endmodule

// File: rtl/pwm3_ctrl_chk.sv
module pwm3_ctrl_chk #(
  parameter int NPH = 3,
  parameter int CW  = 12,
  parameter int DW  = 8,
  parameter int NF  = 3,
  parameter int DUW = CW + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2*NPH-1:0]  gate_o,
  input logic [2*NPH-1:0]  gate_oe_o,
  input logic              adc_trig_o,
  input logic              pol_low_i,
  input logic [NF-1:0]     fault_i,
  input logic              fault_hiz_i,
  input logic              fault_clr_i,
  input logic [CW-1:0]     cnt_w,
  input logic [CW-1:0]     period_act,
  input logic [DW-1:0]     dead_act,
  input logic              load_evt,
  input logic [NPH*DUW-1:0] duty_act_flat,
  input logic              force_w,
  input logic              fault_latched
);
  logic [2*NPH-1:0] on_w;
  logic [NPH-1:0]   both_w;
  assign on_w = (gate_o ^ {(2*NPH){pol_low_i}}) & gate_oe_o;

  generate
    for (genvar k = 0; k < NPH; k++) begin : g_pair
      assign both_w[k] = on_w[2*k] & on_w[2*k+1];
      // R4: handover keeps the other side off while a dead time is set
      p_dead_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dead_act != '0 && !force_w && $fell(on_w[2*k])) |-> !on_w[2*k+1]);
    end
  endgenerate

  p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    both_w == '0);

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_w <= period_act);

  p_shadow_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(duty_act_flat));

  p_fault_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|fault_i) |-> (fault_hiz_i ? (gate_oe_o == '0)
                                : (gate_oe_o == '1 && gate_o == {(2*NPH){pol_low_i}})));

  p_latch_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_latched && !fault_clr_i) |=> fault_latched);

  p_trig_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_trig_o && period_act != '0) |=> !adc_trig_o);
endmodule

bind pwm3_ctrl pwm3_ctrl_chk #(.NPH(NPH), .CW(CW), .DW(DW), .NF(NF)) u_chk (
  .clk(clk), .rst_n(rst_n), .gate_o(gate_o), .gate_oe_o(gate_oe_o),
  .adc_trig_o(adc_trig_o), .pol_low_i(pol_low_i), .fault_i(fault_i),
  .fault_hiz_i(fault_hiz_i), .fault_clr_i(fault_clr_i), .cnt_w(cnt_w),
  .period_act(period_act), .dead_act(dead_act), .load_evt(load_evt),
  .duty_act_flat(duty_act_flat), .force_w(force_w), .fault_latched(fault_latched)
);

// File: tb/pwm3_ctrl_bench.sv
module pwm3_ctrl_bench;
  localparam int CW = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        center_i = 1'b0;
  logic [11:0] period_i = '0;
  logic [35:0] duty_i = '0;
  logic [7:0]  dead_i = '0;
  logic [11:0] trig_pt_i = '0;
  logic        pol_low_i = 1'b0;
  logic [2:0]  fault_i = '0;
  logic        fault_hiz_i = 1'b0;
  logic        fault_clr_i = 1'b0;
  logic [5:0]  gate_o, gate_oe_o;
  logic        adc_trig_o;

  always #10 clk = ~clk;

  pwm3_ctrl u_pwm3_ctrl (
    .clk(clk), .rst_n(rst_n), .center_i(center_i), .period_i(period_i),
    .duty_i(duty_i), .dead_i(dead_i), .trig_pt_i(trig_pt_i), .pol_low_i(pol_low_i),
    .fault_i(fault_i), .fault_hiz_i(fault_hiz_i), .fault_clr_i(fault_clr_i),
    .gate_o(gate_o), .gate_oe_o(gate_oe_o), .adc_trig_o(adc_trig_o)
  );

  typedef struct { string tag; int val; } exp_t;
  exp_t exp_q[$];
  int n_chk = 0, n_fail = 0, overlaps = 0;
  bit done = 1'b0;

  // driver side: push expected value
  task automatic expect_val(string tag, int v);
    exp_t e;
    e.tag = tag; e.val = v;
    exp_q.push_back(e);
  endtask

  // monitor side: pop and compare
  task automatic observe(int actual);
    exp_t e;
    n_chk++;
    if (exp_q.size() == 0) begin
      n_fail++;
      $display("FAIL scoreboard empty: actual %0d expected none", actual);
    end else begin
      e = exp_q.pop_front();
      if (actual != e.val) begin
        n_fail++;
        $display("FAIL %s: actual %0d expected %0d", e.tag, actual, e.val);
      end
    end
  endtask

  // continuous overlap monitor (R3), from the ports
  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < 3; k++) begin
        if (((gate_o[2*k] ^ pol_low_i) & gate_oe_o[2*k]) &&
            ((gate_o[2*k+1] ^ pol_low_i) & gate_oe_o[2*k+1]))
          overlaps++;
      end
    end
  end

  task automatic wait_rise(int idx);
    @(negedge clk);
    while (gate_o[idx]) @(negedge clk);
    while (!gate_o[idx]) @(negedge clk);
  endtask

  task automatic width_after_rise(int idx, output int w);
    w = 0;
    while (gate_o[idx]) begin w++; @(negedge clk); end
  endtask

  task automatic count_high(int idx, int cycles, output int h);
    h = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (gate_o[idx]) h++;
    end
  endtask

  task automatic set_cfg(bit c, int p, int d0, int d1, int d2, int dd, int tp);
    center_i = c; period_i = 12'(p); dead_i = 8'(dd); trig_pt_i = 12'(tp);
    duty_i = {12'(d2), 12'(d1), 12'(d0)};
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int w, h, g;
    set_cfg(1'b0, 99, 30, 50, 70, 4, 20);
    repeat (4) @(negedge clk);
    // R3: all gates inactive in reset
    expect_val("R3 reset gates", 0);       observe(int'(gate_o));
    expect_val("R8 reset enables", 63);    observe(int'(gate_oe_o));
    expect_val("R11 reset trigger", 0);    observe(int'(adc_trig_o));
    @(negedge clk); rst_n = 1'b1;
    repeat (600) @(negedge clk);

    // R1/R2: edge mode widths per phase
    wait_rise(0); width_after_rise(0, w); expect_val("R1 R2 phase0 high", 26); observe(w);
    wait_rise(2); width_after_rise(2, w); expect_val("R1 R2 phase1 high", 46); observe(w);
    wait_rise(4); width_after_rise(4, w); expect_val("R1 R2 phase2 high", 66); observe(w);
    wait_rise(1); width_after_rise(1, w); expect_val("R2 phase0 low", 66);     observe(w);

    // R4: gap between high-side fall and low-side rise
    wait_rise(0); width_after_rise(0, w);
    g = 0; while (!gate_o[1]) begin g++; @(negedge clk); end
    expect_val("R4 dead gap", 4); observe(g);

    // R11: trigger lag and interval
    wait_rise(0);
    g = 0; while (!adc_trig_o) begin g++; @(negedge clk); end
    expect_val("R11 trigger lag", 16); observe(g);
    @(negedge clk);
    g = 1; while (!adc_trig_o) begin g++; @(negedge clk); end
    expect_val("R11 trigger interval", 100); observe(g);

    // R6: compare written mid-pulse leaves current pulse intact
    wait_rise(0);
    duty_i[11:0] = 12'd10;
    width_after_rise(0, w); expect_val("R6 pulse in flight", 26); observe(w);
    wait_rise(0); width_after_rise(0, w); expect_val("R6 next pulse", 6); observe(w);

    // R7: runt suppression both directions (2D = 8)
    set_cfg(1'b0, 99, 7, 93, 70, 4, 20);
    repeat (300) @(negedge clk);
    count_high(0, 300, h); expect_val("R7 short high suppressed", 0);   observe(h);
    count_high(2, 300, h); expect_val("R7 short low gives full on", 300); observe(h);

    // R5: center mode
    set_cfg(1'b1, 50, 10, 20, 30, 3, 5);
    repeat (400) @(negedge clk);
    wait_rise(0); width_after_rise(0, w); expect_val("R5 center high", 16); observe(w);
    wait_rise(1); width_after_rise(1, w); expect_val("R5 center low", 78);  observe(w);
    wait_rise(2); width_after_rise(2, w); expect_val("R5 center phase1 high", 36); observe(w);
    @(negedge clk); while (!adc_trig_o) @(negedge clk);
    @(negedge clk);
    g = 1; while (!adc_trig_o) begin g++; @(negedge clk); end
    expect_val("R5 R11 center trigger interval", 100); observe(g);

    // R8: immediate inactive forcing
    @(negedge clk); fault_i = 3'b010; #1;
    expect_val("R8 inactive gates", 0);   observe(int'(gate_o));
    expect_val("R8 enables kept", 63);    observe(int'(gate_oe_o));
    repeat (5) @(negedge clk); fault_i = '0;
    repeat (6) @(negedge clk);
    // R9: still forced after inputs return low
    count_high(0, 120, h); expect_val("R9 latched after fault", 0); observe(h);
    fault_clr_i = 1'b1; @(negedge clk); fault_clr_i = 1'b0;
    count_high(0, 150, h); expect_val("R9 released after clear", 1); observe(int'(h > 0));

    // R8: high impedance option
    fault_hiz_i = 1'b1; fault_i = 3'b100; #1;
    expect_val("R8 hiz enables", 0); observe(int'(gate_oe_o));
    repeat (5) @(negedge clk); fault_i = '0;
    repeat (5) @(negedge clk); fault_clr_i = 1'b1; @(negedge clk); fault_clr_i = 1'b0;
    fault_hiz_i = 1'b0;

    // R10: active-low polarity
    pol_low_i = 1'b1;
    set_cfg(1'b1, 50, 10, 51, 30, 3, 5);
    repeat (300) @(negedge clk);
    expect_val("R10 active high side low", 0);    observe(int'(gate_o[2]));
    expect_val("R10 inactive low side high", 1);  observe(int'(gate_o[3]));
    fault_i = 3'b001; #1;
    expect_val("R10 R8 inactive level high", 63); observe(int'(gate_o));
    repeat (5) @(negedge clk); fault_i = '0;

    expect_val("R3 no overlap seen", 0); observe(overlaps);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule